// File: doc/BRIEF.md
# Wavefront Cross-Lane Permutation Unit

This block moves one 32-bit value per lane across a 64-lane wavefront. A 9-bit control word selects how lanes are routed. Lanes form rows of sixteen and quads of four. The available routings are:

- a free crossbar inside each quad;
- row-local shifts and rotates by 1 to 15 lanes;
- single-lane shifts and rotates across the whole wavefront;
- mirrors of each row and of each half-row;
- two broadcasts that copy one lane into later rows.

The result starts as a copy of an "old" vector. A lane is overwritten only when both its row-enable bit and its bank-enable bit are set. A zero-fill flag decides what a lane receives when its routing has no valid source.

A request is accepted on a valid/ready handshake. One cycle after acceptance the result vector, a one-cycle done pulse and an illegal-control flag appear on registered outputs. The result vector holds its value until the next accepted request. Element types narrower than 32 bits are zero-extended into the lane value before they reach the block.

Top module: `xlane_perm`

## Requirements
- R1: While reset is high and on the first cycle after it, `done` and `bad_ctrl` are 0. `req_ready` is 1 whenever reset is low.
- R2: When a request is accepted (`req_valid` and `req_ready` both high at a rising edge), `done` is 1 in the following cycle only. When no request is accepted, `res_vec` keeps its value.
- R3: Quad crossbar, control values 0x000 to 0x0FF. Lane `i` of each quad takes source lane `4*(i/4) + ctrl[2*(i%4)+1 : 2*(i%4)]`.
- R4: Row shifts. Control 0x100+n (n = 1..15) gives lane with row position p the source at row position p+n. Control 0x110+n gives it row position p-n. A position outside 0..15 means the lane has no source.
- R5: Row rotate. Control 0x120+n (n = 1..15) gives row position p the source at row position (p-n) mod 16.
- R6: Wavefront moves by one lane. 0x130 gives lane l the source lane l+1, with no source for lane 63. 0x134 gives lane l the source lane (l+1) mod 64. 0x138 gives lane l the source lane l-1, with no source for lane 0. 0x13C gives lane l the source lane (l-1) mod 64.
- R7: Mirrors. 0x140 gives row position p the source at position 15-p of the same row. 0x141 gives position p the source at position 7-(p mod 8) of the same half-row.
- R8: Broadcasts. 0x142 writes source lane 16r-1 into every lane of row r, for r = 1..3; row 0 has no source. 0x143 writes source lane 31 into rows 2 and 3; rows 0 and 1 have no source.
- R9: Write enables. Row-enable bit r covers lanes 16r..16r+15. Bank-enable bit b covers lanes whose row position has bits [3:2] equal to b. A lane that lacks either enable keeps its old value.
- R10: An enabled lane with no source receives 0 when `zero_fill` is 1, and keeps its old value when `zero_fill` is 0.
- R11: Some control values are illegal: any code from 0x100 upward that R4 to R8 do not list, which includes shift or rotate amounts of 0. An illegal code leaves every lane at its old value, whatever the enables and `zero_fill`. `bad_ctrl` is 1 in the `done` cycle. For legal codes `bad_ctrl` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A request is presented |
| req_ready | output | 1 | The block can accept a request |
| ctrl | input | 9 | Lane-routing control word |
| row_en | input | 4 | Per-row write enables |
| bank_en | input | 4 | Per-bank write enables |
| zero_fill | input | 1 | Write zero into enabled lanes that have no source |
| src_vec | input | 2048 | Source lanes, lane l at bits [32l+31:32l] |
| old_vec | input | 2048 | Starting values of the result lanes |
| res_vec | output | 2048 | Registered result lanes |
| done | output | 1 | One-cycle pulse after an accepted request |
| bad_ctrl | output | 1 | The control word of the finished request was illegal |

## Verification
The corner cases are edge lanes and the encodings that sit next to each other.

- **Row shifts.** A shift that crosses a row boundary, instead of treating that lane as having no source, leaks data from the neighbouring row.
- **Wavefront moves.** Swapping the shift and rotate variants changes only lane 0 or lane 63.
- **Broadcasts.** Row 0 under either broadcast, and row 1 under the lane-31 broadcast, must show `zero_fill` behaviour rather than a copied lane.
- **Masks.** Illegal codes and all-zero enables are driven with `zero_fill` set. A design that lets either path write zeros instead of old data shows up there.
- **Bank enables.** Single-bit bank patterns expose a design that decodes the bank from the wrong index bits.

// File: rtl/xlane_perm.sv
module xlane_perm #(
  parameter int WIDTH = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [8:0]             ctrl,
  input  logic [3:0]             row_en,
  input  logic [3:0]             bank_en,
  input  logic                   zero_fill,
  input  logic [64*WIDTH-1:0]    src_vec,
  input  logic [64*WIDTH-1:0]    old_vec,
  output logic [64*WIDTH-1:0]    res_vec,
  output logic                   done,
  output logic                   bad_ctrl
);
  localparam int LANES = 64;
  localparam int VW    = LANES * WIDTH;

  localparam logic [3:0] K_QUAD = 4'd0,  K_SHL  = 4'd1,  K_SHR  = 4'd2,
                         K_ROR  = 4'd3,  K_WSHL = 4'd4,  K_WROL = 4'd5,
                         K_WSHR = 4'd6,  K_WROR = 4'd7,  K_MIR  = 4'd8,
                         K_HMIR = 4'd9,  K_B15  = 4'd10, K_B31  = 4'd11,
                         K_BAD  = 4'd15;

  logic [3:0]    kind;
  logic [3:0]    amt;
  logic          illegal;
  logic          accept;
  logic [VW-1:0] next_vec;

  assign req_ready = ~rst;
  assign accept    = req_valid & req_ready;
  assign amt       = ctrl[3:0];
  assign illegal   = (kind == K_BAD);

  always_comb begin
    kind = K_BAD;
    if (!ctrl[8]) begin
      kind = K_QUAD;
    end else begin
      case (ctrl[7:4])
        4'h0: kind = (amt != 4'd0) ? K_SHL : K_BAD;
        4'h1: kind = (amt != 4'd0) ? K_SHR : K_BAD;
        4'h2: kind = (amt != 4'd0) ? K_ROR : K_BAD;
        4'h3: begin
          case (amt)
            4'h0:    kind = K_WSHL;
            4'h4:    kind = K_WROL;
            4'h8:    kind = K_WSHR;
            4'hC:    kind = K_WROR;
            default: kind = K_BAD;
          endcase
        end
        4'h4: begin
          case (amt)
            4'h0:    kind = K_MIR;
            4'h1:    kind = K_HMIR;
            4'h2:    kind = K_B15;
            4'h3:    kind = K_B31;
            default: kind = K_BAD;
          endcase
        end
        default: kind = K_BAD;
      endcase
    end
  end

  // returns {has_source, source_lane}
  function automatic logic [6:0] route(input logic [5:0] l, input logic [3:0] k,
                                       input logic [3:0] n, input logic [7:0] q);
    logic [3:0] p;
    logic [4:0] sum;
    logic [7:0] qs;
    logic       v;
    logic [5:0] s;
    p   = l[3:0];
    sum = {1'b0, p} + {1'b0, n};
    qs  = q >> {l[1:0], 1'b0};
    v   = 1'b1;
    s   = l;
    case (k)
      K_QUAD: s = {l[5:2], qs[1:0]};
      K_SHL:  begin v = ~sum[4];  s = {l[5:4], sum[3:0]}; end
      K_SHR:  begin v = (p >= n); s = {l[5:4], p - n};    end
      K_ROR:  s = {l[5:4], p - n};
      K_WSHL: begin v = (l != 6'd63); s = l + 6'd1; end
      K_WROL: s = l + 6'd1;
      K_WSHR: begin v = (l != 6'd0);  s = l - 6'd1; end
      K_WROR: s = l - 6'd1;
      K_MIR:  s = {l[5:4], ~p};
      K_HMIR: s = {l[5:3], ~l[2:0]};
      K_B15:  begin v = (l[5:4] != 2'd0); s = {l[5:4] - 2'd1, 4'hF}; end
      K_B31:  begin v = l[5];             s = 6'd31;                 end
      default: begin v = 1'b0; s = l; end
    endcase
    return {v, s};
  endfunction

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [6:0]       rt;
    logic             wr_en;
    logic [WIDTH-1:0] old_l;
    logic [WIDTH-1:0] src_l;
    assign rt    = route(6'(g), kind, amt, ctrl[7:0]);
    assign wr_en = row_en[g / 16] & bank_en[(g % 16) / 4] & ~illegal;
    assign old_l = old_vec[g*WIDTH +: WIDTH];
    assign src_l = src_vec[rt[5:0]*WIDTH +: WIDTH];
    always_comb begin
      if (!wr_en)      next_vec[g*WIDTH +: WIDTH] = old_l;
      else if (rt[6])  next_vec[g*WIDTH +: WIDTH] = src_l;
      else if (zero_fill) next_vec[g*WIDTH +: WIDTH] = '0;
      else             next_vec[g*WIDTH +: WIDTH] = old_l;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done     <= 1'b0;
      bad_ctrl <= 1'b0;
      res_vec  <= '0;
    end else begin
      done <= accept;
      if (accept) begin
        bad_ctrl <= illegal;
        res_vec  <= next_vec;
      end else begin
        bad_ctrl <= 1'b0;
      end
    end
  end

  AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    accept |=> done);                                                   // R2
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (rst)
    !accept |=> !done && $stable(res_vec));                            // R2
  AST_ILLEGAL_KEEPS_OLD: assert property (@(posedge clk) disable iff (rst)
    (accept && illegal) |=> bad_ctrl && res_vec == $past(old_vec));     // R11
  AST_NO_ROWS_KEEPS_OLD: assert property (@(posedge clk) disable iff (rst)
    (accept && row_en == 4'h0) |=> res_vec == $past(old_vec));          // R9
  AST_WAVE_ROL_LANE0: assert property (@(posedge clk) disable iff (rst)
    (accept && ctrl == 9'h134 && row_en == 4'hF && bank_en == 4'hF)
      |=> res_vec[WIDTH-1:0] == $past(src_vec[2*WIDTH-1:WIDTH]));       // R6
  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> !done && !bad_ctrl);                                 // R1
endmodule

// File: tb/xlane_perm_tb_top.sv
module xlane_perm_tb_top;
  localparam int W = 32;
  localparam int VW = 64 * W;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [8:0]    ctrl = '0;
  logic [3:0]    row_en = 4'hF;
  logic [3:0]    bank_en = 4'hF;
  logic          zero_fill = 1'b0;
  logic [VW-1:0] src_vec = '0;
  logic [VW-1:0] old_vec = '0;
  logic [VW-1:0] res_vec;
  logic          done;
  logic          bad_ctrl;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  xlane_perm #(.WIDTH(W)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .ctrl(ctrl), .row_en(row_en), .bank_en(bank_en), .zero_fill(zero_fill),
    .src_vec(src_vec), .old_vec(old_vec), .res_vec(res_vec),
    .done(done), .bad_ctrl(bad_ctrl));

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<100000", cycles);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit legal(input int c);
    if (c < 256) return 1;
    if (c > 256 && c < 304 && (c % 16) != 0) return 1;
    if (c == 304 || c == 308 || c == 312 || c == 316) return 1;
    if (c >= 320 && c <= 323) return 1;
    return 0;
  endfunction

  // returns source lane, or -1 when the lane has no source
  function automatic int src_of(input int c, input int l);
    int r = l / 16, p = l % 16, n = c % 16;
    if (c < 256) return (l / 4) * 4 + ((c >> (2 * (l % 4))) & 3);
    if (c < 272) return (p + n < 16) ? r * 16 + p + n : -1;
    if (c < 288) return (p - n >= 0) ? r * 16 + p - n : -1;
    if (c < 304) return r * 16 + ((p - n + 16) % 16);
    if (c == 304) return (l < 63) ? l + 1 : -1;
    if (c == 308) return (l + 1) % 64;
    if (c == 312) return (l > 0) ? l - 1 : -1;
    if (c == 316) return (l + 63) % 64;
    if (c == 320) return r * 16 + 15 - p;
    if (c == 321) return (l / 8) * 8 + 7 - (l % 8);
    if (c == 322) return (r > 0) ? r * 16 - 1 : -1;
    return (r >= 2) ? 31 : -1;
  endfunction

  function automatic logic [VW-1:0] model(input int c, input logic [3:0] re, input logic [3:0] be,
                                          input bit zf, input logic [VW-1:0] s, input logic [VW-1:0] o);
    logic [VW-1:0] e = o;
    if (!legal(c)) return e;
    for (int l = 0; l < 64; l++) begin
      int k;
      if (re[l / 16] && be[(l % 16) / 4]) begin
        k = src_of(c, l);
        if (k >= 0) e[l*W +: W] = s[k*W +: W];
        else if (zf) e[l*W +: W] = '0;
      end
    end
    return e;
  endfunction

  task automatic fill_data();
    for (int l = 0; l < 64; l++) begin
      src_vec[l*W +: W] = $urandom();
      old_vec[l*W +: W] = $urandom();
    end
  endtask

  task automatic run_op(input int c, input logic [3:0] re, input logic [3:0] be, input bit zf, input string req);
    logic [VW-1:0] exp_v;
    logic [VW-1:0] held;
    @(negedge clk);
    ctrl = 9'(c); row_en = re; bank_en = be; zero_fill = zf;
    exp_v = model(c, re, be, zf, src_vec, old_vec);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(done == 1'b1, "R2 done pulse", 64'(done), 64'd1);
    chk(bad_ctrl == !legal(c), "R11 bad_ctrl flag", 64'(bad_ctrl), 64'(!legal(c)));
    checks++;
    if (res_vec !== exp_v) begin
      errors++;
      for (int l = 0; l < 64; l++)
        if (res_vec[l*W +: W] !== exp_v[l*W +: W]) begin
          $display("FAIL %s ctrl=%0h lane %0d: actual=%0h expected=%0h",
                   req, c, l, res_vec[l*W +: W], exp_v[l*W +: W]);
          break;
        end
    end
    held = res_vec;
    fill_data();
    @(negedge clk);
    chk(done == 1'b0, "R2 single-cycle done", 64'(done), 64'd0);
    chk(res_vec === held, "R2 result held", res_vec[63:0], held[63:0]);
  endtask

  function automatic int rand_ctrl();
    int sel = $urandom_range(0, 11);
    case (sel)
      0: return $urandom_range(0, 255);
      1: return 256 + $urandom_range(1, 15);
      2: return 272 + $urandom_range(1, 15);
      3: return 288 + $urandom_range(1, 15);
      4: return 304;
      5: return 308;
      6: return 312;
      7: return 316;
      8: return 320;
      9: return 321;
      10: return 322 + $urandom_range(0, 1);
      default: return $urandom_range(256, 511);
    endcase
  endfunction

  initial begin
    void'($urandom(32'd12345));
    fill_data();
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R1 done in reset", 64'(done), 64'd0);
    chk(req_ready == 1'b0, "R1 ready in reset", 64'(req_ready), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(done == 1'b0 && bad_ctrl == 1'b0, "R1 quiet after reset", 64'({done, bad_ctrl}), 64'd0);
    chk(req_ready == 1'b1, "R1 ready after reset", 64'(req_ready), 64'd1);

    run_op(9'h091, 4'hF, 4'hF, 0, "R3 quad [1,0,1,2]");
    run_op(9'h058, 4'hF, 4'hF, 0, "R3 quad [0,2,1,1]");
    run_op(9'h10F, 4'hF, 4'hF, 1, "R4 row shl 15 zero");
    run_op(9'h101, 4'hF, 4'hF, 0, "R4 row shl 1 keep");
    run_op(9'h11F, 4'hF, 4'hF, 1, "R4 row shr 15");
    run_op(9'h12A, 4'hF, 4'hF, 0, "R5 row ror 10");
    run_op(9'h130, 4'hF, 4'hF, 1, "R6 wave shl");
    run_op(9'h134, 4'hF, 4'hF, 1, "R6 wave rol");
    run_op(9'h138, 4'hF, 4'hF, 1, "R6 wave shr");
    run_op(9'h13C, 4'hF, 4'hF, 1, "R6 wave ror");
    run_op(9'h140, 4'hF, 4'hF, 0, "R7 row mirror");
    run_op(9'h141, 4'hF, 4'hF, 0, "R7 half mirror");
    run_op(9'h142, 4'hF, 4'hF, 1, "R8 bcast15 zero");
    run_op(9'h143, 4'hF, 4'hF, 1, "R8 bcast31 zero");
    run_op(9'h143, 4'hF, 4'hF, 0, "R10 bcast31 keep");
    run_op(9'h140, 4'h0, 4'hF, 1, "R9 no rows");
    run_op(9'h140, 4'hA, 4'h1, 0, "R9 row A bank 1");
    run_op(9'h130, 4'h5, 4'h4, 1, "R9 bank 2 only");
    run_op(9'h100, 4'hF, 4'hF, 1, "R11 shl amount 0");
    run_op(9'h131, 4'hF, 4'hF, 1, "R11 wave gap code");
    run_op(9'h1FF, 4'hF, 4'hF, 1, "R11 top code");
    for (int t = 0; t < 300; t++)
      run_op(rand_ctrl(), 4'($urandom()), 4'($urandom()), 1'($urandom()), "R3-R11 random");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule